// File: doc/BRIEF.md
# Accumulator Barrel Shifter

This block is the shift stage of a 40-bit signal-processing datapath. In each cycle it takes one of three operands: a 40-bit accumulator value, a 16-bit data word, or a 16-bit immediate. It widens the operand to 40 bits, shifts it by a signed count, and registers the outcome. The full 40-bit result feeds the main arithmetic unit. Its low 16 bits feed the narrower address arithmetic unit.

The count comes from one of two places. It is either one of four temporary count registers, picked by a select field, or a constant field carried with the operation. A positive count shifts left and a negative count shifts right. Accumulator and data operands can move up to 31 places left or 32 places right. Immediates move only left, and at most 15 places. A carry output records the last bit pushed out of the word.

Top module: `acc_shift_unit`

## Requirements
- R1: `op_sel` picks the operand: 2'b00 accumulator (40 bits as is), 2'b01 data word, 2'b10 immediate; 2'b11 is treated as accumulator. Both 16-bit operands are sign-extended from their bit 15 to 40 bits.
- R2: When `cnt_src` is 1, the count is `const_cnt`. When `cnt_src` is 0, the count is the 6-bit slice `treg_cnts[6*k +: 6]`, where k is `treg_sel`.
- R3: The count is a 6-bit two's-complement value. A positive count shifts left and fills with zeros. A negative count shifts right arithmetically, filling with bit 39 of the widened operand.
- R4: Accumulator and data operands accept every count from -32 (right 32) to +31 (left 31). A count beyond either limit is clamped to that limit.
- R5: An immediate operand shifts left only. A count above 15 acts as 15, and a negative count leaves the immediate unshifted.
- R6: `carry_out` is the last bit shifted out of the 40-bit widened operand. A left shift by n gives bit 40-n and a right shift by n gives bit n-1. The value is 0 when the effective count is zero.
- R7: The result appears one cycle after `in_valid` is sampled high. `out_valid` is `in_valid` delayed by one cycle. While `in_valid` is low, `result`, `addr_result` and `carry_out` hold their values.
- R8: `addr_result` always equals bits 15:0 of `result`.
- R9: While `rst_n` is low, `out_valid`, `result`, `addr_result` and `carry_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Operation present this cycle |
| op_sel | input | 2 | Operand kind |
| acc_in | input | 40 | Accumulator operand |
| data_in | input | 16 | Data-word operand |
| imm_in | input | 16 | Immediate operand |
| cnt_src | input | 1 | 0 = count register, 1 = constant |
| treg_sel | input | 2 | Count register index |
| treg_cnts | input | 24 | Four packed 6-bit count registers |
| const_cnt | input | 6 | Constant count field |
| out_valid | output | 1 | Result valid |
| result | output | 40 | Shifted result |
| addr_result | output | 16 | Low half for the address unit |
| carry_out | output | 1 | Last bit shifted out |

## Verification
The bench aims at the extreme counts +31 and -32. A design that sized its shifter one stage short, or that read the count as unsigned, would lose the right shift by 32 or send it left. Operands with bit 15 or bit 39 set show up any zero-extension or logical right fill as wrong upper bits. Immediates given counts of 16 to 31 and negative counts show whether the immediate clamp is applied or skipped. The carry is checked against the exact boundary bit, and at count zero, where an off-by-one index or a missing zero guard would give a stray 1.

// File: rtl/acs_pkg.sv
package acs_pkg;
   typedef enum logic [1:0] {
      OPD_ACC  = 2'b00,
      OPD_DATA = 2'b01,
      OPD_IMM  = 2'b10,
      OPD_RSV  = 2'b11
   } opd_kind_e;

   typedef enum logic {
      DIR_LEFT  = 1'b0,
      DIR_RIGHT = 1'b1
   } shift_dir_e;
endpackage

// File: rtl/acs_operand_ext.sv
module acs_operand_ext
   import acs_pkg::*;
#(
   parameter int ACC_W    = 40,
   parameter int OPD_W    = 16,
   parameter bit SIGN_EXT = 1'b1
) (
   input  opd_kind_e          kind_i,
   input  logic [ACC_W-1:0]   acc_i,
   input  logic [OPD_W-1:0]   data_i,
   input  logic [OPD_W-1:0]   imm_i,
   output logic [ACC_W-1:0]   ext_o
);
   localparam int PAD_W = ACC_W - OPD_W;

   logic [ACC_W-1:0] data_wide;
   logic [ACC_W-1:0] imm_wide;

   generate
      if (OPD_W >= ACC_W) begin : g_bad_width
         $error("acs_operand_ext: OPD_W must be narrower than ACC_W");
      end
      if (SIGN_EXT) begin : g_sext
         assign data_wide = {{PAD_W{data_i[OPD_W-1]}}, data_i};
         assign imm_wide  = {{PAD_W{imm_i[OPD_W-1]}}, imm_i};
      end else begin : g_zext
         assign data_wide = {{PAD_W{1'b0}}, data_i};
         assign imm_wide  = {{PAD_W{1'b0}}, imm_i};
      end
   endgenerate

   always_comb begin
      unique case (kind_i)
         OPD_DATA: ext_o = data_wide;
         OPD_IMM:  ext_o = imm_wide;
         default:  ext_o = acc_i;
      endcase
   end
endmodule

// File: rtl/acs_count_sel.sv
module acs_count_sel
   import acs_pkg::*;
#(
   parameter int CNT_W        = 6,
   parameter int NUM_TREG     = 4,
   parameter int MAX_LEFT     = 31,
   parameter int MAX_RIGHT    = 32,
   parameter int IMM_MAX_LEFT = 15,
   localparam int TSEL_W      = (NUM_TREG > 1) ? $clog2(NUM_TREG) : 1,
   localparam int AMT_W       = $clog2(MAX_RIGHT + 1)
) (
   input  logic                       cnt_src_i,
   input  logic [TSEL_W-1:0]          treg_sel_i,
   input  logic [NUM_TREG*CNT_W-1:0]  treg_cnts_i,
   input  logic [CNT_W-1:0]           const_cnt_i,
   input  opd_kind_e                  kind_i,
   output shift_dir_e                 dir_o,
   output logic [AMT_W-1:0]           amt_o
);
   localparam int MAG_W = CNT_W + 1;
   localparam logic [MAG_W-1:0] LIM_L = MAG_W'(MAX_LEFT);
   localparam logic [MAG_W-1:0] LIM_R = MAG_W'(MAX_RIGHT);
   localparam logic [MAG_W-1:0] LIM_I = MAG_W'(IMM_MAX_LEFT);

   logic [CNT_W-1:0] tregs [NUM_TREG];
   logic [CNT_W-1:0] raw_cnt;
   logic             is_neg;
   logic [MAG_W-1:0] raw_ext;
   logic [MAG_W-1:0] mag;
   logic [MAG_W-1:0] clamped;

   generate
      if (IMM_MAX_LEFT > MAX_LEFT) begin : g_bad_imm
         $error("acs_count_sel: immediate limit exceeds left limit");
      end
      if (MAX_LEFT > MAX_RIGHT) begin : g_bad_lr
         $error("acs_count_sel: amount width sized from right limit");
      end
      for (genvar t = 0; t < NUM_TREG; t++) begin : g_treg
         assign tregs[t] = treg_cnts_i[t*CNT_W +: CNT_W];
      end
   endgenerate

   assign raw_cnt = cnt_src_i ? const_cnt_i : tregs[treg_sel_i];
   assign is_neg  = raw_cnt[CNT_W-1];
   assign raw_ext = {is_neg, raw_cnt};
   assign mag     = is_neg ? (~raw_ext + MAG_W'(1)) : raw_ext;

   always_comb begin
      dir_o   = DIR_LEFT;
      clamped = '0;
      if (kind_i == OPD_IMM) begin
         if (!is_neg) clamped = (mag > LIM_I) ? LIM_I : mag;
      end else if (is_neg) begin
         dir_o   = DIR_RIGHT;
         clamped = (mag > LIM_R) ? LIM_R : mag;
      end else begin
         clamped = (mag > LIM_L) ? LIM_L : mag;
      end
   end

   assign amt_o = AMT_W'(clamped);
endmodule

// File: rtl/acs_barrel.sv
module acs_barrel
   import acs_pkg::*;
#(
   parameter int ACC_W       = 40,
   parameter int MAX_RIGHT   = 32,
   parameter bit ARITH_RIGHT = 1'b1,
   localparam int AMT_W      = $clog2(MAX_RIGHT + 1)
) (
   input  logic [ACC_W-1:0]  opd_i,
   input  shift_dir_e        dir_i,
   input  logic [AMT_W-1:0]  amt_i,
   output logic [ACC_W-1:0]  shifted_o,
   output logic              carry_o
);
   localparam int IDX_W = $clog2(ACC_W);

   logic             fill;
   logic [ACC_W-1:0] lstage [AMT_W+1];
   logic [ACC_W-1:0] rstage [AMT_W+1];
   logic [IDX_W-1:0] lidx;
   logic [IDX_W-1:0] ridx;

   generate
      if ((1 << (AMT_W - 1)) >= ACC_W) begin : g_bad_stage
         $error("acs_barrel: largest stage must be below the word width");
      end
      if (ARITH_RIGHT) begin : g_arith
         assign fill = opd_i[ACC_W-1];
      end else begin : g_logic
         assign fill = 1'b0;
      end
      assign lstage[0] = opd_i;
      assign rstage[0] = opd_i;
      for (genvar k = 0; k < AMT_W; k++) begin : g_stage
         localparam int S = 1 << k;
         assign lstage[k+1] = amt_i[k] ? {lstage[k][ACC_W-S-1:0], {S{1'b0}}} : lstage[k];
         assign rstage[k+1] = amt_i[k] ? {{S{fill}}, rstage[k][ACC_W-1:S]} : rstage[k];
      end
   endgenerate

   assign shifted_o = (dir_i == DIR_RIGHT) ? rstage[AMT_W] : lstage[AMT_W];

   assign lidx = IDX_W'(ACC_W) - IDX_W'(amt_i);
   assign ridx = IDX_W'(amt_i) - IDX_W'(1);

   always_comb begin
      if (amt_i == '0)              carry_o = 1'b0;
      else if (dir_i == DIR_RIGHT)  carry_o = opd_i[ridx];
      else                          carry_o = opd_i[lidx];
   end
endmodule

// File: rtl/acc_shift_unit.sv
module acc_shift_unit
   import acs_pkg::*;
#(
   parameter int ACC_W        = 40,
   parameter int OPD_W        = 16,
   parameter int CNT_W        = 6,
   parameter int NUM_TREG     = 4,
   parameter int MAX_LEFT     = 31,
   parameter int MAX_RIGHT    = 32,
   parameter int IMM_MAX_LEFT = 15,
   parameter int ADDR_W       = 16,
   parameter bit SIGN_EXT     = 1'b1,
   parameter bit ARITH_RIGHT  = 1'b1,
   localparam int TSEL_W      = (NUM_TREG > 1) ? $clog2(NUM_TREG) : 1
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       in_valid,
   input  logic [1:0]                 op_sel,
   input  logic [ACC_W-1:0]           acc_in,
   input  logic [OPD_W-1:0]           data_in,
   input  logic [OPD_W-1:0]           imm_in,
   input  logic                       cnt_src,
   input  logic [TSEL_W-1:0]          treg_sel,
   input  logic [NUM_TREG*CNT_W-1:0]  treg_cnts,
   input  logic [CNT_W-1:0]           const_cnt,
   output logic                       out_valid,
   output logic [ACC_W-1:0]           result,
   output logic [ADDR_W-1:0]          addr_result,
   output logic                       carry_out
);
   localparam int AMT_W = $clog2(MAX_RIGHT + 1);

   generate
      if (ADDR_W > ACC_W) begin : g_bad_addr
         $error("acc_shift_unit: address output wider than result");
      end
   endgenerate

   opd_kind_e        kind;
   logic [ACC_W-1:0] ext_opd;
   shift_dir_e       dir;
   logic [AMT_W-1:0] amt;
   logic [ACC_W-1:0] shifted;
   logic             carry_c;

   assign kind = opd_kind_e'(op_sel);

   acs_operand_ext #(
      .ACC_W(ACC_W), .OPD_W(OPD_W), .SIGN_EXT(SIGN_EXT)
   ) i_ext (
      .kind_i(kind), .acc_i(acc_in), .data_i(data_in), .imm_i(imm_in), .ext_o(ext_opd)
   );

   acs_count_sel #(
      .CNT_W(CNT_W), .NUM_TREG(NUM_TREG), .MAX_LEFT(MAX_LEFT),
      .MAX_RIGHT(MAX_RIGHT), .IMM_MAX_LEFT(IMM_MAX_LEFT)
   ) i_cnt (
      .cnt_src_i(cnt_src), .treg_sel_i(treg_sel), .treg_cnts_i(treg_cnts),
      .const_cnt_i(const_cnt), .kind_i(kind), .dir_o(dir), .amt_o(amt)
   );

   acs_barrel #(
      .ACC_W(ACC_W), .MAX_RIGHT(MAX_RIGHT), .ARITH_RIGHT(ARITH_RIGHT)
   ) i_barrel (
      .opd_i(ext_opd), .dir_i(dir), .amt_i(amt), .shifted_o(shifted), .carry_o(carry_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         carry_out <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            result    <= shifted;
            carry_out <= carry_c;
         end
      end
   end

   assign addr_result = result[ADDR_W-1:0];

   // Count selection limits
   assert_imm_left_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && kind == OPD_IMM) |-> (dir == DIR_LEFT && amt <= AMT_W'(IMM_MAX_LEFT)));
   assert_right_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dir == DIR_RIGHT) |-> (amt != '0 && amt <= AMT_W'(MAX_RIGHT)));
   assert_left_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dir == DIR_LEFT) |-> (amt <= AMT_W'(MAX_LEFT)));
   // Output register behaviour
   assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_drops_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_hold_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(result) && $stable(carry_out)));
   assert_zero_count_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && amt == '0) |=> (carry_out == 1'b0 && result == $past(ext_opd)));
   assert_addr_low_half_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (addr_result == result[ADDR_W-1:0]));
endmodule

// File: tb/test_acc_shift_unit.sv
`timescale 1ns/1ps
module test_acc_shift_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  op_sel = '0;
   logic [39:0] acc_in = '0;
   logic [15:0] data_in = '0;
   logic [15:0] imm_in = '0;
   logic        cnt_src = 1'b0;
   logic [1:0]  treg_sel = '0;
   logic [23:0] treg_cnts = '0;
   logic [5:0]  const_cnt = '0;
   logic        out_valid;
   logic [39:0] result;
   logic [15:0] addr_result;
   logic        carry_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   acc_shift_unit i_acc_shift_unit (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel),
      .acc_in(acc_in), .data_in(data_in), .imm_in(imm_in), .cnt_src(cnt_src),
      .treg_sel(treg_sel), .treg_cnts(treg_cnts), .const_cnt(const_cnt),
      .out_valid(out_valid), .result(result), .addr_result(addr_result),
      .carry_out(carry_out)
   );

   task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Behavioural reference: widen, pick count, shift, last bit out.
   function automatic void model(input logic [1:0] op, input logic [39:0] a,
                                 input logic [15:0] d, input logic [15:0] im,
                                 input int c_in, output logic [39:0] r, output logic co);
      logic signed [39:0] x;
      int c = c_in;
      case (op)
         2'b01:   x = 40'(signed'(d));
         2'b10:   x = 40'(signed'(im));
         default: x = a;
      endcase
      if (op == 2'b10) begin
         if (c < 0)  c = 0;
         if (c > 15) c = 15;
      end
      if (c > 0) begin
         r = x << c;  co = x[40 - c];
      end else if (c < 0) begin
         r = x >>> (-c); co = x[-c - 1];
      end else begin
         r = x; co = 1'b0;
      end
   endfunction

   // Apply one operation, tick, compare.
   task automatic op(input string req, input logic [1:0] o, input logic [39:0] a,
                     input logic [15:0] d, input logic [15:0] im, input logic src,
                     input logic [1:0] ts, input logic [23:0] tr, input logic [5:0] k);
      logic [39:0] er;
      logic        ec;
      logic [5:0]  used;
      in_valid = 1'b1; op_sel = o; acc_in = a; data_in = d; imm_in = im;
      cnt_src = src; treg_sel = ts; treg_cnts = tr; const_cnt = k;
      used = src ? k : tr[ts*6 +: 6];
      model(o, a, d, im, int'($signed(used)), er, ec);
      @(posedge clk); #1;
      check({req, " valid"}, 40'(out_valid), 40'(1));
      check({req, " result"}, result, er);
      check({req, " carry R6"}, 40'(carry_out), 40'(ec));
      check("R8 addr", 40'(addr_result), 40'(result[15:0]));
   endtask

   initial begin
      #(200000 * 4);
      if (!done) begin
         fails++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [39:0] held_r;
      logic        held_c;
      repeat (3) @(posedge clk);
      #1;
      check("R9 reset valid", 40'(out_valid), 40'(0));
      check("R9 reset result", result, 40'(0));
      check("R9 reset addr", 40'(addr_result), 40'(0));
      check("R9 reset carry", 40'(carry_out), 40'(0));
      rst_n = 1'b1;
      @(posedge clk); #1;

      // R1/R3: operands and directions
      op("R1 acc left",  2'b00, 40'h00_8000_0001, 16'h0, 16'h0, 1, 0, 0, 6'd4);
      op("R1 data sext", 2'b01, 40'h0, 16'h8001, 16'h0, 1, 0, 0, 6'd0);
      op("R1 imm sext",  2'b10, 40'h0, 16'h0, 16'hF234, 1, 0, 0, 6'd3);
      op("R1 rsv acc",   2'b11, 40'h12_3456_789A, 16'h0, 16'h0, 1, 0, 0, 6'd1);
      op("R3 arith right", 2'b00, 40'h80_0000_00F0, 16'h0, 16'h0, 1, 0, 0, 6'h3C);
      op("R3 data right",  2'b01, 40'h0, 16'hC003, 16'h0, 1, 0, 0, 6'h3F);
      // R4: range edges
      op("R4 left 31",  2'b00, 40'h00_0000_0003, 16'h0, 16'h0, 1, 0, 0, 6'd31);
      op("R4 right 32", 2'b00, 40'hA5_8000_0000, 16'h0, 16'h0, 1, 0, 0, 6'h20);
      op("R4 data l31", 2'b01, 40'h0, 16'h8001, 16'h0, 1, 0, 0, 6'd31);
      op("R4 data r32", 2'b01, 40'h0, 16'h8000, 16'h0, 1, 0, 0, 6'h20);
      // R5: immediate clamp and negative
      op("R5 imm clamp", 2'b10, 40'h0, 16'h0, 16'h0003, 1, 0, 0, 6'd31);
      op("R5 imm 16",    2'b10, 40'h0, 16'h0, 16'h8001, 1, 0, 0, 6'd16);
      op("R5 imm neg",   2'b10, 40'h0, 16'h0, 16'h8421, 1, 0, 0, 6'h3E);
      // R2: register source, each slot
      for (int t = 0; t < 4; t++)
         op("R2 treg", 2'b00, 40'hF0_0F0F_1234, 16'h0, 16'h0, 0, 2'(t),
            {6'h3B, 6'd9, 6'h20, 6'd5}, 6'd0);
      op("R2 const wins", 2'b00, 40'h00_0000_0001, 16'h0, 16'h0, 1, 2, {4{6'd7}}, 6'd2);
      // R6: zero count
      op("R6 zero", 2'b00, 40'hFF_FFFF_FFFF, 16'h0, 16'h0, 1, 0, 0, 6'd0);

      // R7: hold while idle
      held_r = result; held_c = carry_out;
      in_valid = 1'b0; acc_in = 40'h55_5555_5555; const_cnt = 6'd1;
      @(posedge clk); #1;
      check("R7 idle valid", 40'(out_valid), 40'(0));
      check("R7 idle hold", result, held_r);
      check("R7 idle carry", 40'(carry_out), 40'(held_c));

      for (int i = 0; i < 300; i++)
         op("R3 random", 2'($urandom), {$urandom, $urandom}, 16'($urandom), 16'($urandom),
            1'($urandom), 2'($urandom), 24'($urandom), 6'($urandom));

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule